// File: doc/BRIEF.md
# Multi-Latency Pipelined Execution Tracker

This block tracks the timing of instructions through a set of fully pipelined, universal function units in an out-of-order core. It carries no operands and computes no results. Each of `LANES` issue lanes can accept one instruction per cycle. The instruction arrives with an operation class, a sequence tag and an optional destination register. The block holds each instruction for the latency its class selects, then presents it on a completion broadcast.

The broadcast has one slot for each pairing of lane and operation class, so it is `LANES*3` slots wide. Instructions of different classes issued on one lane at different cycles can therefore finish in the same cycle without contention. The number of completions in a cycle is never limited.

Each completion slot carries the tag, for waking up dependent instructions in the scheduler. The block also drives a per-register done mask, which the register status table uses to mark destinations ready. Instructions with no destination still complete, but they leave the mask untouched.

Top module: `exe_track`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with no issue, every `comp_valid` bit and every `reg_done` bit is 0.
- R2: The 2-bit class code sets the latency: code 0 is 1 cycle, code 1 is 2 cycles and code 2 is 5 cycles. An instruction sampled at the clock edge that ends cycle t is shown on the completion bus during cycle t+L. Code 3 is an illegal input.
- R3: An instruction issued on lane i with class k completes in slot i*3+k. Slot s occupies bits [s*TAG_W +: TAG_W] of `comp_tag` and [s*REG_W +: REG_W] of `comp_dst`.
- R4: A completion slot carries the issued tag, destination-valid flag and destination register unchanged.
- R5: A lane accepts a new instruction every cycle. Back-to-back issues of one class each complete in consecutive cycles, in issue order.
- R6: Every instruction due in a cycle completes in that cycle, even when more than `LANES` are due at once.
- R7: A completing instruction whose destination-valid flag is 0 still raises its `comp_valid` bit, but sets no `reg_done` bit.
- R8: In any cycle, bit r of `reg_done` is 1 exactly when some valid completion slot has its destination-valid flag set and destination r.
- R9: Each issued instruction is shown on the bus for exactly one cycle.
- R10: A lane whose issue-valid bit is 0 inserts nothing, whatever its other issue fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | LANES | Issue valid, one bit per lane |
| iss_op | input | 2*LANES | Class code per lane (0, 1 or 2) |
| iss_tag | input | TAG_W*LANES | Sequence tag per lane |
| iss_dst_vld | input | LANES | Destination present, per lane |
| iss_dst | input | REG_W*LANES | Destination register per lane |
| comp_valid | output | 3*LANES | Completion valid per slot |
| comp_tag | output | TAG_W*3*LANES | Completed tag per slot |
| comp_dst_vld | output | 3*LANES | Destination present per slot |
| comp_dst | output | REG_W*3*LANES | Destination register per slot |
| reg_done | output | 2**REG_W | Registers written this cycle |

## Verification
A class-0 result is due one cycle after its issue edge, a class-1 result two cycles after, and a class-2 result five cycles after. `reg_done` follows in the same cycle as its slot, because it is a purely combinational decode. Each bench task drives its inputs on a falling edge and counts rising edges from the issue edge. It samples on the next falling edge at the cycle where the result is due. It also samples the cycles before and after, to confirm that the slot is quiet there. This shows both the exact latency and that each result lasts a single cycle.

// File: rtl/exe_track_pkg.sv
// Shared constants for the execution tracker: class codes and the
// latency each class selects. Assumes exactly three legal classes.
package exe_track_pkg;

    localparam int NUM_CLASSES = 3;
    localparam int OP_W        = 2;
    localparam int MAX_LAT     = 5;

    typedef enum logic [OP_W-1:0] {
        OPC_SHORT = 2'd0,
        OPC_MID   = 2'd1,
        OPC_LONG  = 2'd2,
        OPC_BAD   = 2'd3
    } op_class_e;

    // Latency in cycles for a class index 0..NUM_CLASSES-1.
    function automatic int class_latency(input int k);
        case (k)
            0:       return 1;
            1:       return 2;
            default: return MAX_LAT;
        endcase
    endfunction

endpackage

// File: rtl/exe_lat_pipe.sv
// Fixed-depth delay line for one latency class on one lane. An entry
// loaded at an edge leaves the stage-0 output DEPTH-1 edges later.
// Assumes DEPTH >= 1; payload is not reset, only the valid bits are.
module exe_lat_pipe #(
    parameter int DEPTH = 1,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_vld,
    input  logic [W-1:0] ld_dat,
    output logic         out_vld,
    output logic [W-1:0] out_dat
);

    logic [DEPTH-1:0] vld_q;
    logic [W-1:0]     dat_q [DEPTH];

    // Tail stage takes the newly issued entry.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q[DEPTH-1] <= 1'b0;
        else        vld_q[DEPTH-1] <= ld_vld;
        dat_q[DEPTH-1] <= ld_dat;
    end

    generate
        if (DEPTH > 1) begin : g_shift
            for (genvar s = 0; s < DEPTH-1; s++) begin : g_stage
                // Advance one stage toward the output each cycle.
                always_ff @(posedge clk) begin
                    if (!rst_n) vld_q[s] <= 1'b0;
                    else        vld_q[s] <= vld_q[s+1];
                    dat_q[s] <= dat_q[s+1];
                end
            end
        end
    endgenerate

    assign out_vld = vld_q[0];
    assign out_dat = dat_q[0];

endmodule

// File: rtl/exe_lane.sv
// One universal, fully pipelined function unit. It decodes the class
// code and steers the issue into the delay line of matching depth.
// One delay line per class lets different classes finish together.
// Assumes the class code is 0..2 whenever iss_vld is high; code 3 is dropped.
module exe_lane
    import exe_track_pkg::*;
#(
    parameter int TAG_W = 8,
    parameter int REG_W = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         iss_vld,
    input  logic [OP_W-1:0]              iss_op,
    input  logic [TAG_W-1:0]             iss_tag,
    input  logic                         iss_dv,
    input  logic [REG_W-1:0]             iss_dst,
    output logic [NUM_CLASSES-1:0]       c_vld,
    output logic [NUM_CLASSES*TAG_W-1:0] c_tag,
    output logic [NUM_CLASSES-1:0]       c_dv,
    output logic [NUM_CLASSES*REG_W-1:0] c_dst
);

    localparam int PW = TAG_W + 1 + REG_W;

    logic [NUM_CLASSES-1:0] sel;
    logic [PW-1:0]          payload;

    // One-hot class select; an illegal code selects nothing.
    always_comb begin
        sel = '0;
        if (iss_vld && iss_op != OPC_BAD) sel[iss_op] = 1'b1;
    end

    assign payload = {iss_tag, iss_dv, iss_dst};

    generate
        for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_cls
            logic [PW-1:0] o_dat;
            exe_lat_pipe #(.DEPTH(class_latency(k)), .W(PW)) u_pipe (
                .clk     (clk),
                .rst_n   (rst_n),
                .ld_vld  (sel[k]),
                .ld_dat  (payload),
                .out_vld (c_vld[k]),
                .out_dat (o_dat)
            );
            assign c_tag[k*TAG_W +: TAG_W] = o_dat[PW-1 -: TAG_W];
            assign c_dv[k]                 = o_dat[REG_W];
            assign c_dst[k*REG_W +: REG_W] = o_dat[REG_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/exe_reg_wakeup.sv
// Folds every completion slot into a per-register done mask for the
// register status table. Purely combinational; slots without a destination are skipped.
module exe_reg_wakeup #(
    parameter int SLOTS = 12,
    parameter int REG_W = 7
) (
    input  logic [SLOTS-1:0]       s_vld,
    input  logic [SLOTS-1:0]       s_dv,
    input  logic [SLOTS*REG_W-1:0] s_dst,
    output logic [(1<<REG_W)-1:0]  mask
);

    // Set the bit of each destination written this cycle.
    always_comb begin
        mask = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (s_vld[s] && s_dv[s]) mask[s_dst[s*REG_W +: REG_W]] = 1'b1;
        end
    end

endmodule

// File: rtl/exe_track.sv
// Top of the execution tracker. LANES universal pipelined units feed a
// completion broadcast with one slot per (lane, class) pair, slot index
// lane*3+class, plus a register done mask. Assumes the issuer presents
// only legal class codes. The completion bus has no backpressure.
module exe_track
    import exe_track_pkg::*;
#(
    parameter int LANES = 4,
    parameter int TAG_W = 8,
    parameter int REG_W = 7
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [LANES-1:0]                 iss_valid,
    input  logic [OP_W*LANES-1:0]            iss_op,
    input  logic [TAG_W*LANES-1:0]           iss_tag,
    input  logic [LANES-1:0]                 iss_dst_vld,
    input  logic [REG_W*LANES-1:0]           iss_dst,
    output logic [NUM_CLASSES*LANES-1:0]     comp_valid,
    output logic [TAG_W*NUM_CLASSES*LANES-1:0] comp_tag,
    output logic [NUM_CLASSES*LANES-1:0]     comp_dst_vld,
    output logic [REG_W*NUM_CLASSES*LANES-1:0] comp_dst,
    output logic [(1<<REG_W)-1:0]            reg_done
);

    localparam int SLOTS = NUM_CLASSES * LANES;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            exe_lane #(.TAG_W(TAG_W), .REG_W(REG_W)) u_lane (
                .clk     (clk),
                .rst_n   (rst_n),
                .iss_vld (iss_valid[i]),
                .iss_op  (iss_op[i*OP_W +: OP_W]),
                .iss_tag (iss_tag[i*TAG_W +: TAG_W]),
                .iss_dv  (iss_dst_vld[i]),
                .iss_dst (iss_dst[i*REG_W +: REG_W]),
                .c_vld   (comp_valid[i*NUM_CLASSES +: NUM_CLASSES]),
                .c_tag   (comp_tag[i*NUM_CLASSES*TAG_W +: NUM_CLASSES*TAG_W]),
                .c_dv    (comp_dst_vld[i*NUM_CLASSES +: NUM_CLASSES]),
                .c_dst   (comp_dst[i*NUM_CLASSES*REG_W +: NUM_CLASSES*REG_W])
            );
        end
    endgenerate

    exe_reg_wakeup #(.SLOTS(SLOTS), .REG_W(REG_W)) u_wake (
        .s_vld (comp_valid),
        .s_dv  (comp_dst_vld),
        .s_dst (comp_dst),
        .mask  (reg_done)
    );

endmodule

// File: rtl/exe_track_chk.sv
// Timing and broadcast checks for exe_track, attached by bind.
module exe_track_chk
    import exe_track_pkg::*;
#(
    parameter int LANES = 4,
    parameter int TAG_W = 8,
    parameter int REG_W = 7
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [LANES-1:0]                 iss_valid,
    input logic [OP_W*LANES-1:0]            iss_op,
    input logic [TAG_W*LANES-1:0]           iss_tag,
    input logic [LANES-1:0]                 iss_dst_vld,
    input logic [REG_W*LANES-1:0]           iss_dst,
    input logic [NUM_CLASSES*LANES-1:0]     comp_valid,
    input logic [TAG_W*NUM_CLASSES*LANES-1:0] comp_tag,
    input logic [NUM_CLASSES*LANES-1:0]     comp_dst_vld,
    input logic [REG_W*NUM_CLASSES*LANES-1:0] comp_dst,
    input logic [(1<<REG_W)-1:0]            reg_done
);

    localparam int SLOTS = NUM_CLASSES * LANES;

    // R7: a done bit needs some completing slot that has a destination.
    assert_done_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_done != '0) |-> ((comp_valid & comp_dst_vld) != '0));

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_l
            // R2: class code 3 must never be issued.
            assert_legal_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
                iss_valid[i] |-> (iss_op[i*OP_W +: OP_W] != OPC_BAD));
            // R2: short class is due one cycle later.
            assert_short_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (iss_valid[i] && iss_op[i*OP_W +: OP_W] == OPC_SHORT)
                |=> comp_valid[i*NUM_CLASSES]);
            // R2: middle class is due two cycles later.
            assert_mid_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (iss_valid[i] && iss_op[i*OP_W +: OP_W] == OPC_MID)
                |-> ##2 comp_valid[i*NUM_CLASSES+1]);
            // R2: long class is due five cycles later.
            assert_long_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (iss_valid[i] && iss_op[i*OP_W +: OP_W] == OPC_LONG)
                |-> ##5 comp_valid[i*NUM_CLASSES+2]);
            // R10: a short-class slot only fires after a short-class issue.
            assert_no_phantom_R10: assert property (@(posedge clk) disable iff (!rst_n)
                comp_valid[i*NUM_CLASSES]
                |-> $past(iss_valid[i] && iss_op[i*OP_W +: OP_W] == OPC_SHORT));
            // R4: short-class tag is carried unchanged.
            assert_tag_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (iss_valid[i] && iss_op[i*OP_W +: OP_W] == OPC_SHORT)
                |=> comp_tag[i*NUM_CLASSES*TAG_W +: TAG_W] == $past(iss_tag[i*TAG_W +: TAG_W]));
        end
        for (genvar s = 0; s < SLOTS; s++) begin : g_s
            // R8: every completing destination raises its done bit.
            assert_done_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (comp_valid[s] && comp_dst_vld[s]) |-> reg_done[comp_dst[s*REG_W +: REG_W]]);
        end
    endgenerate

endmodule

bind exe_track exe_track_chk #(.LANES(LANES), .TAG_W(TAG_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/sim_exe_track.sv
// Directed bench for exe_track: one task per scenario.
module sim_exe_track;

    localparam int LANES = 4;
    localparam int TAG_W = 8;
    localparam int REG_W = 7;
    localparam int SLOTS = 3 * LANES;
    localparam int NREG  = 1 << REG_W;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [LANES-1:0]         iss_valid;
    logic [2*LANES-1:0]       iss_op;
    logic [TAG_W*LANES-1:0]   iss_tag;
    logic [LANES-1:0]         iss_dst_vld;
    logic [REG_W*LANES-1:0]   iss_dst;
    logic [SLOTS-1:0]         comp_valid;
    logic [TAG_W*SLOTS-1:0]   comp_tag;
    logic [SLOTS-1:0]         comp_dst_vld;
    logic [REG_W*SLOTS-1:0]   comp_dst;
    logic [NREG-1:0]          reg_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    exe_track #(.LANES(LANES), .TAG_W(TAG_W), .REG_W(REG_W)) u0 (.*);

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_in();
        iss_valid = '0; iss_op = '0; iss_tag = '0; iss_dst_vld = '0; iss_dst = '0;
    endtask

    task automatic put(input int ln, input int op, input int tag, input bit dv, input int dst);
        iss_valid[ln]              = 1'b1;
        iss_op[ln*2 +: 2]          = 2'(op);
        iss_tag[ln*TAG_W +: TAG_W] = TAG_W'(tag);
        iss_dst_vld[ln]            = dv;
        iss_dst[ln*REG_W +: REG_W] = REG_W'(dst);
    endtask

    function automatic logic [127:0] tag_of(input int s);
        return 128'(comp_tag[s*TAG_W +: TAG_W]);
    endfunction

    function automatic logic [127:0] dst_of(input int s);
        return 128'(comp_dst[s*REG_W +: REG_W]);
    endfunction

    // R1: quiet outputs after reset.
    task automatic t_reset();
        check("R1 valid", 128'(comp_valid), 0);
        check("R1 done", 128'(reg_done), 0);
    endtask

    // R2/R3/R4/R9: each class on lane 1, single-cycle result at t+L.
    task automatic t_latency(input int op, input int lat);
        int s;
        s = 1*3 + op;
        put(1, op, 40 + op, 1'b1, 20 + op);
        tick();
        clear_in();
        for (int c = 1; c <= 7; c++) begin
            check("R2/R9 slot valid", 128'(comp_valid[s]), 128'(c == lat));
            check("R3 only one slot", 128'($countones(comp_valid)), 128'(c == lat));
            if (c == lat) begin
                check("R4 tag", tag_of(s), 128'(40 + op));
                check("R4 dst", dst_of(s), 128'(20 + op));
                check("R4 dst_vld", 128'(comp_dst_vld[s]), 1);
            end
            tick();
        end
    endtask

    // R5: back-to-back middle-class issues on lane 0.
    task automatic t_pipelined();
        for (int j = 0; j < 4; j++) begin
            clear_in();
            put(0, 1, 10 + j, 1'b1, j);
            tick();
            if (j >= 1) begin
                check("R5 valid", 128'(comp_valid[1]), 1);
                check("R5 tag", tag_of(1), 128'(10 + j - 1));
            end
        end
        clear_in();
        tick();
        check("R5 last valid", 128'(comp_valid[1]), 1);
        check("R5 last tag", tag_of(1), 13);
        tick();
        check("R5 drained", 128'(comp_valid), 0);
    endtask

    // R6: six completions in one cycle on a four-lane unit.
    task automatic t_burst();
        put(2, 2, 60, 1'b1, 60);
        tick(); clear_in();
        tick(); tick();
        put(2, 1, 61, 1'b1, 61);
        tick(); clear_in();
        put(2, 0, 62, 1'b1, 62);
        put(0, 0, 63, 1'b1, 63);
        put(1, 0, 64, 1'b1, 64);
        put(3, 0, 65, 1'b1, 65);
        tick(); clear_in();
        check("R6 count", 128'($countones(comp_valid)), 6);
        check("R6 lane2 long tag", tag_of(8), 60);
        check("R6 lane2 mid tag", tag_of(7), 61);
        check("R6 lane2 short tag", tag_of(6), 62);
        tick();
        check("R6 drained", 128'(comp_valid), 0);
    endtask

    // R7/R8: destination-less completion and the done mask.
    task automatic t_regs();
        logic [NREG-1:0] exp;
        put(3, 0, 70, 1'b0, 5);
        tick(); clear_in();
        check("R7 still completes", 128'(comp_valid[9]), 1);
        check("R7 no done bit", 128'(reg_done), 0);
        put(0, 0, 71, 1'b1, 9);
        put(1, 0, 72, 1'b1, 100);
        put(2, 0, 73, 1'b1, 9);
        tick(); clear_in();
        exp = '0; exp[9] = 1'b1; exp[100] = 1'b1;
        check("R8 done mask", 128'(reg_done), 128'(exp));
        tick();
        check("R8 mask clears", 128'(reg_done), 0);
    endtask

    // R10: inactive lanes ignore their other fields.
    task automatic t_idle();
        iss_valid = '0;
        iss_op = 8'b10_01_00_10; iss_tag = '1; iss_dst_vld = '1; iss_dst = '1;
        tick(); tick(); tick();
        clear_in();
        for (int c = 0; c < 4; c++) begin
            check("R10 no completion", 128'(comp_valid), 0);
            check("R10 no done", 128'(reg_done), 0);
            tick();
        end
    endtask

    initial begin
        clear_in();
        repeat (3) tick();
        check("R1 in reset", 128'(comp_valid), 0);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_latency(0, 1);
        t_latency(1, 2);
        t_latency(2, 5);
        t_pipelined();
        t_burst();
        t_regs();
        t_idle();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20000 * 4);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule